// File: doc/BRIEF.md
# Two-Way Register Mailbox Master

This block is the host side of a sixteen-byte, two-way register mailbox that sits behind a byte-wide register bus. A caller presents a 16-byte buffer, a write mask and a read mask, then pulses `start`. The engine first wins the mailbox by arbitration. It reads a status register and drains a stale reply if one is pending. It then writes the command byte and checks that the master-write flag came up.

After winning, it writes the selected argument bytes in ascending order. The final data register is always written, with the value 0x01, because that write hands control to the slave. The engine then polls status until the slave reports that its output buffer is full. It reads back the selected bytes, and the last register is always read because that read clears the slave's status. Completion is a one-cycle `done` pulse with an error flag and a code that separates lost arbitration from a missing response.

Waits between retries are timed in microseconds from a tick derived from `CLK_HZ`. Every bus access uses a request/acknowledge handshake.

Top module: `mbox_master`

## Requirements
- R1: After reset `busy`, `done`, `err` and `bus_req` are low and `err_code` is 0; no bus request is raised while `busy` is low.
- R2: Once raised, `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` stable until `bus_ack` is sampled high. Each cycle with both high completes exactly one access, and `bus_rdata` is taken in that cycle.
- R3: Each arbitration attempt reads status at `STAT_ADDR` (0x04). If bit 6 (output full) or bit 4 (slave writing) is set, the attempt fails and one dummy read of `DATA_BASE`+15 follows, with no wait. Otherwise byte 0 is written to `DATA_BASE` (0x10) and status is read again. Bit 5 (master writing) set means the mailbox is won. Bit 7 has no effect.
- R4: An attempt rejected after the command write waits `ARB_GAP_US` microseconds before the next status read.
- R5: If all `ARB_TRIES` attempts fail, the transaction ends with `err`=1 and `err_code`=1, and no argument byte is written and no byte is read back.
- R6: After winning, byte n (bits 8n+7:8n of `cmd_buf`) is written to `DATA_BASE`+n for n = 1..15 in ascending order, only where `wr_mask` bit n is set. Bit 15 is treated as set, and byte 15 is always written as 0x01. `wr_mask` bit 0 has no effect.
- R7: The engine then reads status up to `RSP_TRIES` times, `RSP_GAP_US` microseconds apart, until bit 6 is set. If bit 6 never appears, it ends with `err`=1, `err_code`=2 and reads no data.
- R8: On response, `DATA_BASE`+n is read for n = 0..15 in ascending order where `rd_mask` bit n is set. Bit 15 is treated as set. Each value read replaces byte n of `rsp_buf`.
- R9: At `start`, `rsp_buf` takes `cmd_buf`. Bytes that are not read back keep that value, including on error.
- R10: `done` is a one-cycle pulse in the cycle `busy` falls. `err` and `err_code` are valid with it and hold until the next completion; `err_code` is 0 and `err` is 0 on success.
- R11: `start` while `busy` is ignored: the running transaction's bus sequence and result are unchanged by it.
- R12: Reads go only to `STAT_ADDR` or `DATA_BASE`..`DATA_BASE`+15, and writes only to the data window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transaction when idle |
| cmd_buf | input | 128 | Buffer; byte n is bits 8n+7:8n, byte 0 is the command |
| wr_mask | input | 16 | Argument bytes to write |
| rd_mask | input | 16 | Bytes to read back |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transaction failed |
| err_code | output | 2 | 0 ok, 1 arbitration lost, 2 no response |
| rsp_buf | output | 128 | Launched buffer with read bytes replaced |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 8 | Read data, valid with ack |

## Verification
A new `start` can arrive in the same cycle as a pending bus access of a running transaction. The bench provokes this by raising `start` with an inverted buffer and all-ones masks some cycles into a transaction whose slave acknowledges late. It judges the result by comparing the logged access sequence, the write data and `rsp_buf` against the expectation of the original launch. The bench also places a stretched acknowledge over a status poll, and there the request must hold steady across the cycles that the slave model watches.

// File: rtl/mbox_master.sv
module mbox_master #(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          ARB_TRIES  = 100,
  parameter int          RSP_TRIES  = 100,
  parameter int          ARB_GAP_US = 1,
  parameter int          RSP_GAP_US = 500,
  parameter logic [7:0]  STAT_ADDR  = 8'h04,
  parameter logic [7:0]  DATA_BASE  = 8'h10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] cmd_buf,
  input  logic [15:0]  wr_mask,
  input  logic [15:0]  rd_mask,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [1:0]   err_code,
  output logic [127:0] rsp_buf,
  output logic         bus_req,
  output logic         bus_we,
  output logic [7:0]   bus_addr,
  output logic [7:0]   bus_wdata,
  input  logic         bus_ack,
  input  logic [7:0]   bus_rdata
);

  localparam int TPU  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int TW   = $clog2(TPU + 1);
  localparam int MAXT = (ARB_TRIES > RSP_TRIES) ? ARB_TRIES : RSP_TRIES;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int MAXG = (ARB_GAP_US > RSP_GAP_US) ? ARB_GAP_US : RSP_GAP_US;
  localparam int GW   = $clog2(MAXG + 1);
  localparam int B_OBF = 6;
  localparam int B_MWM = 5;
  localparam int B_SWM = 4;
  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_ARB  = 2'd1;
  localparam logic [1:0] E_RSP  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ARB_ST, S_DRAIN, S_CMD, S_ARB_CHK, S_ARB_GAP,
    S_WR, S_POLL, S_POLL_GAP, S_RD
  } st_t;

  st_t            st;
  logic [3:0]     idx;
  logic [15:0]    wm, rm;
  logic [127:0]   buf_q;
  logic [CW-1:0]  tries;
  logic [GW-1:0]  gap;
  logic [TW-1:0]  tick_cnt;
  logic           us_tick, xfer, arb_last, rsp_last;

  assign us_tick  = (tick_cnt == TW'(TPU - 1));
  assign xfer     = bus_req & bus_ack;
  assign arb_last = (tries == CW'(ARB_TRIES - 1));
  assign rsp_last = (tries == CW'(RSP_TRIES - 1));
  assign busy     = (st != S_IDLE);
  assign rsp_buf  = buf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tick_cnt <= '0;
    else if (us_tick) tick_cnt <= '0;
    else              tick_cnt <= tick_cnt + 1'b1;

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = STAT_ADDR;
    bus_wdata = (idx == 4'd15) ? 8'h01 : buf_q[{idx, 3'b000} +: 8];
    case (st)
      S_ARB_ST, S_ARB_CHK, S_POLL: bus_req = 1'b1;
      S_DRAIN: begin
        bus_req  = 1'b1;
        bus_addr = DATA_BASE + 8'd15;
      end
      S_CMD: begin
        bus_req  = 1'b1;
        bus_we   = 1'b1;
        bus_addr = DATA_BASE;
      end
      S_WR: begin
        bus_req  = wm[idx];
        bus_we   = 1'b1;
        bus_addr = DATA_BASE + {4'h0, idx};
      end
      S_RD: begin
        bus_req  = rm[idx];
        bus_addr = DATA_BASE + {4'h0, idx};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      wm       <= '0;
      rm       <= '0;
      buf_q    <= '0;
      tries    <= '0;
      gap      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= E_NONE;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            wm    <= wr_mask | 16'h8000;
            rm    <= rd_mask | 16'h8000;
            buf_q <= cmd_buf;
            idx   <= '0;
            tries <= '0;
            st    <= S_ARB_ST;
          end
        S_ARB_ST:
          if (xfer) st <= (bus_rdata[B_OBF] | bus_rdata[B_SWM]) ? S_DRAIN : S_CMD;
        S_DRAIN:
          if (xfer) begin
            if (arb_last) begin
              st <= S_IDLE; done <= 1'b1; err <= 1'b1; err_code <= E_ARB;
            end else begin
              tries <= tries + 1'b1;
              st    <= S_ARB_ST;
            end
          end
        S_CMD:
          if (xfer) st <= S_ARB_CHK;
        S_ARB_CHK:
          if (xfer) begin
            if (bus_rdata[B_MWM]) begin
              st    <= S_WR;
              idx   <= 4'd1;
              tries <= '0;
            end else if (arb_last) begin
              st <= S_IDLE; done <= 1'b1; err <= 1'b1; err_code <= E_ARB;
            end else begin
              tries <= tries + 1'b1;
              gap   <= '0;
              st    <= S_ARB_GAP;
            end
          end
        S_ARB_GAP:
          if (us_tick) begin
            if (gap == GW'(ARB_GAP_US - 1)) st <= S_ARB_ST;
            else gap <= gap + 1'b1;
          end
        S_WR:
          if (!wm[idx] || xfer) begin
            if (idx == 4'd15) st <= S_POLL;
            else idx <= idx + 1'b1;
          end
        S_POLL:
          if (xfer) begin
            if (bus_rdata[B_OBF]) begin
              st  <= S_RD;
              idx <= '0;
            end else if (rsp_last) begin
              st <= S_IDLE; done <= 1'b1; err <= 1'b1; err_code <= E_RSP;
            end else begin
              tries <= tries + 1'b1;
              gap   <= '0;
              st    <= S_POLL_GAP;
            end
          end
        S_POLL_GAP:
          if (us_tick) begin
            if (gap == GW'(RSP_GAP_US - 1)) st <= S_POLL;
            else gap <= gap + 1'b1;
          end
        S_RD:
          if (!rm[idx] || xfer) begin
            if (xfer) buf_q[{idx, 3'b000} +: 8] <= bus_rdata;
            if (idx == 4'd15) begin
              st <= S_IDLE; done <= 1'b1; err <= 1'b0; err_code <= E_NONE;
            end else idx <= idx + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_master_chk.sv
module mbox_master_chk #(
  parameter logic [7:0] STAT_ADDR = 8'h04,
  parameter logic [7:0] DATA_BASE = 8'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       bus_req,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_ack
);

  logic in_win;
  assign in_win = (8'(bus_addr - DATA_BASE) < 8'd16);

  a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r6_trigger_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == DATA_BASE + 8'd15 |-> bus_wdata == 8'h01);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != 2'd0)));

  a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  a_r12_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> in_win);

  a_r12_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> in_win || bus_addr == STAT_ADDR);

endmodule

bind mbox_master mbox_master_chk #(.STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .err_code(err_code),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack)
);

// File: tb/mbox_master_bench.sv
module mbox_master_bench;
  localparam int CLK_HZ = 4_000_000;
  localparam int TPU = 4;
  localparam int NA = 100;
  localparam int NR = 100;
  localparam int AG = 2;
  localparam int RG = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [127:0] cmd_buf = '0;
  logic [15:0] wr_mask = '0, rd_mask = '0;
  logic busy, done, err;
  logic [1:0] err_code;
  logic [127:0] rsp_buf;
  logic bus_req, bus_we;
  logic [7:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = 8'h00;

  mbox_master #(.CLK_HZ(CLK_HZ), .ARB_TRIES(NA), .RSP_TRIES(NR),
                .ARB_GAP_US(AG), .RSP_GAP_US(RG)) u_mbox_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_buf(cmd_buf),
    .wr_mask(wr_mask), .rd_mask(rd_mask), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .rsp_buf(rsp_buf), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  int cfg_busy = 0, cfg_rej = 0, cfg_rsp = 0, cfg_lat = 0;
  logic [7:0] cfg_key = 8'h00;
  int busy_left, rej_left, rsp_left, mph, wait_cnt = 0;
  int n_drain, n_cmd, n_poll, last_w, last_r, proto_err, data_err, hold_err;
  logic [15:0] wr_seen, rd_seen;
  logic [127:0] m_cmd;
  logic [7:0] m_key, h_addr, h_wd;
  logic h_we;
  int cyc = 0, last_rej_t, ag_min, ag_max, last_poll_t, pg_min, pg_max;

  always @(posedge clk) begin
    logic [7:0] rd;
    int n, iv;
    cyc++;
    bus_ack <= 1'b0;
    if (start && !busy) begin
      busy_left = cfg_busy; rej_left = cfg_rej; rsp_left = cfg_rsp;
      mph = 0; n_drain = 0; n_cmd = 0; n_poll = 0; last_w = 0; last_r = -1;
      proto_err = 0; data_err = 0; hold_err = 0; wr_seen = '0; rd_seen = '0;
      m_cmd = cmd_buf; m_key = cfg_key; last_rej_t = -1; last_poll_t = -1;
      ag_min = 1 << 30; ag_max = 0; pg_min = 1 << 30; pg_max = 0;
    end
    if (bus_req && !bus_ack) begin
      if (wait_cnt == 0) begin
        h_addr = bus_addr; h_we = bus_we; h_wd = bus_wdata;
      end else if (h_addr != bus_addr || h_we != bus_we || h_wd != bus_wdata) hold_err++;
      if (wait_cnt < cfg_lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        rd = 8'h00;
        n = int'(bus_addr) - 16;
        if (!bus_we && bus_addr == 8'h04) begin
          case (mph)
            0: begin
              if (last_rej_t >= 0) begin
                iv = cyc - last_rej_t;
                if (iv < ag_min) ag_min = iv;
                if (iv > ag_max) ag_max = iv;
                last_rej_t = -1;
              end
              if (busy_left > 0) begin
                busy_left--;
                rd = busy_left[0] ? 8'h40 : 8'h10;
              end else rd = 8'h80;
            end
            1: begin
              if (rej_left > 0) begin
                rej_left--; rd = 8'h80; mph = 0; last_rej_t = cyc;
              end else begin
                rd = 8'hA0; mph = 2;
              end
            end
            3: begin
              n_poll++;
              if (last_poll_t >= 0) begin
                iv = cyc - last_poll_t;
                if (iv < pg_min) pg_min = iv;
                if (iv > pg_max) pg_max = iv;
              end
              last_poll_t = cyc;
              if (rsp_left > 0) begin
                rsp_left--; rd = 8'h20;
              end else begin
                rd = 8'h40; mph = 4;
              end
            end
            default: proto_err++;
          endcase
        end else if (n >= 0 && n <= 15) begin
          if (bus_we) begin
            if (mph == 0 && n == 0) begin
              n_cmd++;
              if (bus_wdata != m_cmd[7:0]) data_err++;
              mph = 1;
            end else if (mph == 2 && n > last_w) begin
              last_w = n;
              wr_seen[n] = 1'b1;
              if (bus_wdata != ((n == 15) ? 8'h01 : m_cmd[n*8 +: 8])) data_err++;
              if (n == 15) mph = 3;
            end else proto_err++;
          end else begin
            if (mph == 0 && n == 15) n_drain++;
            else if (mph == 4 && n > last_r) begin
              last_r = n;
              rd_seen[n] = 1'b1;
              rd = m_key + 8'(n * 29);
            end else proto_err++;
          end
        end else proto_err++;
        bus_ack <= 1'b1;
        bus_rdata <= rd;
      end
    end
  end

  function automatic logic [127:0] exp_rsp(logic [127:0] c, logic [15:0] rm, logic [7:0] key, bit ok);
    logic [127:0] r = c;
    if (ok)
      for (int n = 0; n < 16; n++)
        if (rm[n] || n == 15) r[n*8 +: 8] = key + 8'(n * 29);
    return r;
  endfunction

  task automatic run_txn(input logic [127:0] c, input logic [15:0] wm, input logic [15:0] rm,
                         input int nb, input int nj, input int np, input int lat,
                         input bit restart, input string name);
    bit arb_fail, rsp_fail, seen;
    int drains, cmds, polls;
    logic [1:0] ecode;
    logic [15:0] ew, er;
    cfg_busy = nb; cfg_rej = nj; cfg_rsp = np; cfg_lat = lat;
    cfg_key = 8'($urandom);
    @(negedge clk);
    cmd_buf = c; wr_mask = wm; rd_mask = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 30000; k++) begin
      if (restart && k == 8) begin
        start = 1'b1; cmd_buf = ~c; wr_mask = 16'hFFFF; rd_mask = 16'hFFFF;
      end else start = 1'b0;
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    start = 1'b0;
    chk(seen, {name, " R10 done seen"}, 128'(seen), 128'd1);
    arb_fail = (nb + nj + 1) > NA;
    rsp_fail = !arb_fail && np >= NR;
    ecode = arb_fail ? 2'd1 : (rsp_fail ? 2'd2 : 2'd0);
    drains = (arb_fail && nb > NA) ? NA : nb;
    cmds = arb_fail ? NA - drains : nj + 1;
    polls = arb_fail ? 0 : (rsp_fail ? NR : np + 1);
    ew = arb_fail ? 16'h0 : ((wm | 16'h8000) & 16'hFFFE);
    er = (arb_fail || rsp_fail) ? 16'h0 : (rm | 16'h8000);
    chk(err_code == ecode, {name, " R5 R7 R10 err_code"}, 128'(err_code), 128'(ecode));
    chk(err == (ecode != 0), {name, " R10 err"}, 128'(err), 128'(ecode != 0));
    chk(n_drain == drains && n_cmd == cmds, {name, " R3 R5 drain/cmd counts"},
        128'(n_drain * 1000 + n_cmd), 128'(drains * 1000 + cmds));
    chk(wr_seen == ew, {name, " R6 written bytes"}, 128'(wr_seen), 128'(ew));
    chk(n_poll == polls, {name, " R7 polls"}, 128'(n_poll), 128'(polls));
    chk(rd_seen == er, {name, " R8 read bytes"}, 128'(rd_seen), 128'(er));
    chk(rsp_buf == exp_rsp(c, rm, cfg_key, ecode == 0), {name, " R8 R9 rsp_buf"},
        rsp_buf, exp_rsp(c, rm, cfg_key, ecode == 0));
    chk(proto_err == 0 && data_err == 0, {name, " R6 R11 R12 order/data/address"},
        128'(proto_err * 1000 + data_err), 128'd0);
    chk(hold_err == 0, {name, " R2 request hold"}, 128'(hold_err), 128'd0);
    if (lat == 0 && nj > 0 && nb == 0 && !arb_fail)
      chk(ag_min >= (AG - 1) * TPU + 3 && ag_max <= AG * TPU + 2, {name, " R4 retry gap"},
          128'(ag_min * 1000 + ag_max), 128'(((AG - 1) * TPU + 3) * 1000 + AG * TPU + 2));
    if (lat == 0 && np > 0 && !arb_fail)
      chk(pg_min >= (RG - 1) * TPU + 3 && pg_max <= RG * TPU + 2, {name, " R7 poll gap"},
          128'(pg_min * 1000 + pg_max), 128'(((RG - 1) * TPU + 3) * 1000 + RG * TPU + 2));
    @(negedge clk);
    chk(!done && !busy, {name, " R10 single-cycle done"}, 128'({done, busy}), 128'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && err_code == 2'd0 && !bus_req, "R1 reset state",
        128'({busy, done, err, err_code, bus_req}), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !busy, "R1 idle no request", 128'({bus_req, busy}), 128'd0);

    c = {$urandom, $urandom, $urandom, $urandom};
    run_txn(c, 16'h0001, 16'h0002, 0, 0, 0, 0, 0, "mode query");
    run_txn(c, 16'h0003, 16'h000E, 1, 0, 2, 0, 0, "one arg three reads");
    run_txn(c, 16'h000F, 16'h0000, 0, 2, 1, 0, 0, "three args");
    run_txn(c, 16'h0001, 16'hFFFF, 2, 1, 0, 1, 0, "read all");
    run_txn(c, 16'hFFFE, 16'h7FFF, 0, 0, 0, 0, 0, "full write");
    run_txn(c, 16'h0000, 16'h0000, 0, 3, 3, 0, 0, "R4 R6 bare trigger");
    run_txn(c, 16'h0001, 16'h0002, 30, 69, 0, 0, 0, "R5 last attempt wins");
    run_txn(c, 16'h0003, 16'h0002, 30, 70, 0, 0, 0, "R5 attempts exhausted");
    run_txn(c, 16'h0003, 16'h0002, 150, 0, 0, 0, 0, "R5 always draining");
    run_txn(c, 16'h0005, 16'h0006, 0, 0, NR - 1, 0, 0, "R7 last poll answers");
    run_txn(c, 16'h0005, 16'h0006, 0, 0, NR, 0, 0, "R7 no response");
    run_txn(c, 16'h0081, 16'h0102, 1, 1, 2, 3, 1, "R11 start while busy");
    for (int t = 0; t < 36; t++) begin
      c = {$urandom, $urandom, $urandom, $urandom};
      run_txn(c, 16'($urandom), 16'($urandom), $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 4), $urandom_range(0, 2), t % 7 == 3, "random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule